// File: doc/BRIEF.md
# Indexed Palette Lookup Stage

This block sits in the pixel path of one display layer. It turns indexed pixels into 24-bit RGB by looking them up in a 256-entry colour table. Three indexed formats are handled: plain 8-bit luminance, a byte that packs a 4-bit alpha and a 4-bit index, and a 16-bit word that holds an 8-bit alpha and an 8-bit index. Pixels in the direct RGB format are not looked up and leave the block unchanged. A run-time enable chooses whether indexed pixels are translated or passed through raw.

Software, or a loader ahead of the block, fills the table one entry per cycle. Each write gives an 8-bit entry address and one byte each for red, green and blue. The 4-bit index format uses only sixteen entries. Index n reads the entry whose address is n written into both nibbles (0x00, 0x11, ... 0xFF), so a loader for that format must place its colours at those addresses. Every pixel presented with `in_valid` appears at the output exactly one clock later, with its alpha and valid flag aligned to the table read.

The block has no state machine. It is a single pipeline register stage around a synchronous table.

Top module: `clut_stage`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid`, `out_rgb` and `out_alpha` are zero until the first valid pixel has passed through.
- R2: A pixel presented with `in_valid` high produces `out_valid` high on the next clock and at no other time. Results leave in the order the pixels arrived.
- R3: Format code 1 (8-bit luminance, index in `in_pix[7:0]`) with `lut_en` high gives `out_rgb` = the table entry at that index, with `out_alpha` = 0xFF.
- R4: Format code 3 (alpha in `in_pix[15:8]`, index in `in_pix[7:0]`) gives `out_alpha` = `in_pix[15:8]`. With `lut_en` high it gives `out_rgb` = the table entry at the index.
- R5: Format code 2 (alpha nibble in `in_pix[7:4]`, index nibble in `in_pix[3:0]`) reads the table at address {index, index}. `out_alpha` is the alpha nibble written into both halves of the byte.
- R6: With `lut_en` low, the indexed formats (codes 1, 2, 3) give `out_rgb` = `in_pix` unchanged. Alpha still follows R3, R4 and R5.
- R7: Format code 0 (direct RGB) gives `out_rgb` = `in_pix` and `out_alpha` = 0xFF whatever `lut_en` is.
- R8: A write with `wr_en` high stores {`wr_r`,`wr_g`,`wr_b`} at `wr_addr`. Lookups from the next cycle on return the new entry. A lookup of the same address in the same cycle as the write returns the previous entry.
- R9: In a cycle with `in_valid` low, `out_rgb` and `out_alpha` keep their values on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_en | input | 1 | Enables translation of indexed formats for the pixel presented this cycle |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table entry address |
| wr_r | input | 8 | Red value to store |
| wr_g | input | 8 | Green value to store |
| wr_b | input | 8 | Blue value to store |
| in_valid | input | 1 | Pixel present on `in_pix` |
| in_fmt | input | 2 | Pixel format: 0 RGB, 1 L8, 2 A4/L4, 3 A8/L8 |
| in_pix | input | 24 | Pixel word |
| out_valid | output | 1 | Result present |
| out_rgb | output | 24 | Result colour {R,G,B} |
| out_alpha | output | 8 | Result alpha |

## Verification
The palette is loaded with a computed pattern in which every entry is different. Because of that, a wrong address shows up as wrong colours. A design that reads the 4-bit format at the bare nibble instead of the doubled one returns entries 0x00 to 0x0F, and the bench catches it. The same-cycle write/read case is checked for the old value and then for the new one on the next cycle, which exposes a write-first table or a forwarding path. Disabled and direct pixels are checked for raw pass-through with the correct alpha. Idle cycles are checked for held outputs, which exposes registers that load without `in_valid`. Back-to-back and gapped streams check that the one-cycle alignment of valid, alpha and colour does not slip.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        FMT_RGB  = 2'd0,
        FMT_L8   = 2'd1,
        FMT_AL44 = 2'd2,
        FMT_AL88 = 2'd3
    } pix_fmt_e;
endpackage

// File: rtl/clut_index_map.sv
// Decodes a pixel word into table address, alpha and a lookup flag.
module clut_index_map
    import clut_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  pix_fmt_e            fmt,
    input  logic                lut_en,
    input  logic [2*CH_W-1:0]   pix_lo,
    output logic [CH_W-1:0]     rd_addr,
    output logic [CH_W-1:0]     alpha,
    output logic                use_lut
);
    localparam int HW = CH_W / 2;

    logic [HW-1:0] nib_idx;
    logic [HW-1:0] nib_alpha;

    assign nib_idx   = pix_lo[HW-1:0];
    assign nib_alpha = pix_lo[CH_W-1:HW];

    always_comb begin
        rd_addr = pix_lo[CH_W-1:0];
        alpha   = '1;
        use_lut = 1'b0;
        unique case (fmt)
            FMT_RGB: begin
                use_lut = 1'b0;
            end
            FMT_L8: begin
                use_lut = lut_en;
            end
            FMT_AL44: begin
                rd_addr = {nib_idx, nib_idx};
                alpha   = {nib_alpha, nib_alpha};
                use_lut = lut_en;
            end
            FMT_AL88: begin
                alpha   = pix_lo[2*CH_W-1:CH_W];
                use_lut = lut_en;
            end
        endcase
    end
endmodule

// File: rtl/clut_palette_ram.sv
// Synchronous colour table, one write and one read port, read returns old data on collision.
module clut_palette_ram #(
    parameter int CH_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_addr,
    input  logic [3*CH_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [CH_W-1:0]     rd_addr,
    output logic [3*CH_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << CH_W;

    logic [3*CH_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/clut_align_reg.sv
// Enabled pipeline register used to keep side-band data aligned with the table read.
module clut_align_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/clut_stage.sv
module clut_stage
    import clut_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lut_en,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_addr,
    input  logic [CH_W-1:0]     wr_r,
    input  logic [CH_W-1:0]     wr_g,
    input  logic [CH_W-1:0]     wr_b,
    input  logic                in_valid,
    input  logic [1:0]          in_fmt,
    input  logic [3*CH_W-1:0]   in_pix,
    output logic                out_valid,
    output logic [3*CH_W-1:0]   out_rgb,
    output logic [CH_W-1:0]     out_alpha
);
    localparam int RGB_W  = 3 * CH_W;
    localparam int HW     = CH_W / 2;
    localparam int SIDE_W = RGB_W + CH_W + 1;

    pix_fmt_e          fmt;
    logic [CH_W-1:0]   rd_addr;
    logic [CH_W-1:0]   alpha_d;
    logic              use_lut;
    logic [RGB_W-1:0]  lut_rgb;
    logic [RGB_W-1:0]  pix_q;
    logic [CH_W-1:0]   alpha_q;
    logic              use_q;
    logic              vld_q;

    assign fmt = pix_fmt_e'(in_fmt);

    clut_index_map #(.CH_W(CH_W)) i_map (
        .fmt     (fmt),
        .lut_en  (lut_en),
        .pix_lo  (in_pix[2*CH_W-1:0]),
        .rd_addr (rd_addr),
        .alpha   (alpha_d),
        .use_lut (use_lut)
    );

    clut_palette_ram #(.CH_W(CH_W)) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data ({wr_r, wr_g, wr_b}),
        .rd_en   (in_valid && use_lut),
        .rd_addr (rd_addr),
        .rd_data (lut_rgb)
    );

    clut_align_reg #(.W(SIDE_W)) i_side (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .d     ({in_pix, alpha_d, use_lut}),
        .q     ({pix_q, alpha_q, use_q})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
        end
    end

    always_comb begin
        out_valid = vld_q;
        out_alpha = alpha_q;
        out_rgb   = use_q ? lut_rgb : pix_q;
    end

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_rgb) && $stable(out_alpha)));
    // R5
    al44_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == FMT_AL44) |-> (rd_addr[CH_W-1:HW] == rd_addr[HW-1:0]));
    // R4
    al88_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == FMT_AL88) |=> (out_alpha == $past(in_pix[2*CH_W-1:CH_W])));
    // R7
    direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == FMT_RGB) |=> (out_rgb == $past(in_pix) && out_alpha == '1));
    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lut_en) |=> (out_rgb == $past(in_pix)));
endmodule

// File: tb/test_clut_stage.sv
`timescale 1ns/1ps
module test_clut_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lut_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_r = '0;
    logic [7:0]  wr_g = '0;
    logic [7:0]  wr_b = '0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = '0;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic [23:0] out_rgb;
    logic [7:0]  out_alpha;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    logic [23:0] bm [256];
    logic [23:0] q_rgb [$];
    logic [7:0]  q_alpha [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    clut_stage i_clut_stage (
        .clk(clk), .rst_n(rst_n), .lut_en(lut_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_r(wr_r), .wr_g(wr_g), .wr_b(wr_b),
        .in_valid(in_valid), .in_fmt(in_fmt), .in_pix(in_pix),
        .out_valid(out_valid), .out_rgb(out_rgb), .out_alpha(out_alpha)
    );

    function automatic logic [23:0] pal_val(input int i);
        logic [7:0] b = 8'(i);
        return {b ^ 8'h5A, 8'(i * 3), ~b};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic push_exp(input logic [1:0] f, input logic e, input logic [23:0] p, input string tag);
        logic [7:0]  idx;
        logic [7:0]  a;
        logic [23:0] rgb;
        idx = p[7:0];
        a   = 8'hFF;
        case (f)
            2'd2: begin idx = {p[3:0], p[3:0]}; a = {p[7:4], p[7:4]}; end
            2'd3: a = p[15:8];
            default: ;
        endcase
        rgb = (f != 2'd0 && e) ? bm[idx] : p;
        q_rgb.push_back(rgb);
        q_alpha.push_back(a);
        q_tag.push_back(tag);
    endtask

    task automatic cyc(input logic w, input logic [7:0] wa, input logic [23:0] wd,
                       input logic v, input logic [1:0] f, input logic e,
                       input logic [23:0] p, input string tag);
        wr_en = w; wr_addr = wa; {wr_r, wr_g, wr_b} = wd;
        in_valid = v; in_fmt = f; lut_en = e; in_pix = p;
        if (v) push_exp(f, e, p, tag);
        if (w) bm[wa] = wd;
        @(negedge clk);
    endtask

    task automatic px(input logic [1:0] f, input logic e, input logic [23:0] p, input string tag);
        cyc(1'b0, 8'h00, 24'h0, 1'b1, f, e, p, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 24'h0, 1'b0, 2'd0, 1'b0, 24'h0, "");
    endtask

    // Monitor: pops expected results in order and checks idle-cycle hold
    initial begin
        logic [23:0] last_rgb;
        logic [7:0]  last_a;
        last_rgb = '0;
        last_a = '0;
        wait (running);
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (q_rgb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected out_valid actual=1 expected=0");
                end else begin
                    string t;
                    logic [23:0] er;
                    logic [7:0]  ea;
                    t = q_tag.pop_front();
                    er = q_rgb.pop_front();
                    ea = q_alpha.pop_front();
                    check({t, " rgb"}, {8'h0, out_rgb}, {8'h0, er});
                    check({t, " alpha"}, {24'h0, out_alpha}, {24'h0, ea});
                end
            end else begin
                check("R9 hold rgb", {8'h0, out_rgb}, {8'h0, last_rgb});
                check("R9 hold alpha", {24'h0, out_alpha}, {24'h0, last_a});
            end
            last_rgb = out_rgb;
            last_a = out_alpha;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bm[i] = 24'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'h0, out_valid}, 32'h0);
        check("R1 rgb", {8'h0, out_rgb}, 32'h0);
        check("R1 alpha", {24'h0, out_alpha}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {31'h0, out_valid}, 32'h0);
        running = 1'b1;

        // R8 load full table
        for (int i = 0; i < 256; i++) cyc(1'b1, 8'(i), pal_val(i), 1'b0, 2'd0, 1'b0, 24'h0, "");
        idle(2);

        // R3 8-bit luminance, corners then random, back to back
        px(2'd1, 1'b1, 24'h000000, "R3 L8 idx00");
        px(2'd1, 1'b1, 24'h000001, "R3 L8 idx01");
        px(2'd1, 1'b1, 24'hABCD80, "R3 L8 idx80");
        px(2'd1, 1'b1, 24'h0000FF, "R3 L8 idxFF");
        for (int k = 0; k < 16; k++) px(2'd1, 1'b1, 24'($urandom), "R3 L8 rand");
        idle(3);

        // R4 8-bit alpha + 8-bit index
        px(2'd3, 1'b1, 24'h00FF00, "R4 AL88 a=FF");
        px(2'd3, 1'b1, 24'h0000FF, "R4 AL88 a=00");
        for (int k = 0; k < 16; k++) begin
            px(2'd3, 1'b1, 24'($urandom), "R4 AL88 rand");
            if (k % 4 == 3) idle(1);
        end

        // R5 4-bit alpha + 4-bit index: every nibble
        for (int n = 0; n < 16; n++) px(2'd2, 1'b1, {16'hFFFF, 4'(15 - n), 4'(n)}, "R5 AL44");
        idle(2);

        // R6 lookup disabled for each indexed format
        px(2'd1, 1'b0, 24'h123456, "R6 L8 off");
        px(2'd2, 1'b0, 24'h9876A3, "R6 AL44 off");
        px(2'd3, 1'b0, 24'hC0FFEE, "R6 AL88 off");
        px(2'd1, 1'b1, 24'h123456, "R6 L8 re-on");
        px(2'd2, 1'b0, 24'h00003C, "R6 AL44 off2");

        // R7 direct format, both enable settings
        px(2'd0, 1'b1, 24'hA1B2C3, "R7 RGB en");
        px(2'd0, 1'b0, 24'h0F1E2D, "R7 RGB dis");
        idle(1);

        // R8 write and lookup of the same entry in one cycle: old, then new
        cyc(1'b1, 8'h22, 24'hDEAD01, 1'b1, 2'd2, 1'b1, 24'h000052, "R8 AL44 same-cycle old");
        px(2'd2, 1'b1, 24'h000012, "R8 AL44 next new");
        cyc(1'b1, 8'h7E, 24'h5EED42, 1'b1, 2'd1, 1'b1, 24'h00007E, "R8 L8 same-cycle old");
        px(2'd3, 1'b1, 24'h00337E, "R8 AL88 next new");
        cyc(1'b1, 8'h10, 24'h111111, 1'b1, 2'd1, 1'b1, 24'h000011, "R8 write other addr");
        px(2'd1, 1'b1, 24'h000010, "R8 L8 new 10");

        idle(4);
        check("R2 all results delivered", 32'(q_rgb.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule